// File: doc/BRIEF.md
# Processor Clock and Reset Generator

This block turns a fast reference clock and two slower square-wave sources into the clock, reset and ready signals a processor needs. One select input picks either the local oscillator input or an external frequency input. The rising edges of the chosen source advance a divide-by-three counter, which produces a processor clock that is high for one source period and low for the next two. A second stage halves that clock to give a peripheral clock. The raw oscillator level is also passed out as a buffered copy, so that a neighbouring generator can take it as its external source.

All logic runs on the reference clock, and the source inputs are sampled as data. The rising and falling edges of the processor clock are therefore events inside that domain. An asynchronous reset request passes through two synchronizing flops, then reaches the output flop, which loads only on a processor clock falling edge. The output then stays asserted for a minimum number of processor clock periods. A ready input is synchronized and then loaded only on processor clock rising edges. After its own power-on reset the block holds the processor reset asserted for the same minimum width.

Top module: `cpu_clkgen`

## Requirements
- R1: While `rst_n` is low, `cpu_clk`, `per_clk`, `cpu_rdy` and `osc_out` are 0 and `cpu_rst` is 1.
- R2: With `src_sel` at 0 only rising edges of `osc_in` advance the divider, and with `src_sel` at 1 only rising edges of `ext_in` do; edges on the other input change no output.
- R3: The first selected rising edge after reset drives `cpu_clk` high. `cpu_clk` stays high for one source period, stays low for the next two, and then repeats, so it is high for one of every three source periods.
- R4: `per_clk` starts at 0 and toggles on every rising edge of `cpu_clk`, and at no other time.
- R5: `osc_out` equals `osc_in` delayed by one reference cycle, whatever the value of `src_sel`.
- R6: `cpu_rst` changes value only at a falling edge of `cpu_clk`.
- R7: A `rst_req` pulse at least three reference cycles wide sets `cpu_rst` at the next `cpu_clk` falling edge after synchronization. `cpu_rst` then clears at the RST_MIN-th falling edge after that (default 4), so that RST_MIN rising edges of `cpu_clk` occur while it is high. While `rst_req` is held high, `cpu_rst` stays high.
- R8: After `rst_n` is released, `cpu_rst` stays high and clears at the RST_MIN-th falling edge of `cpu_clk`.
- R9: `cpu_rdy` takes the synchronized value of `rdy_in` only at rising edges of `cpu_clk`, and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock that clocks every flop |
| rst_n | input | 1 | Active-low power-on reset of the block |
| src_sel | input | 1 | Source select: 0 oscillator input, 1 external input |
| osc_in | input | 1 | Local oscillator square wave |
| ext_in | input | 1 | External frequency square wave |
| rst_req | input | 1 | Asynchronous reset request, active high |
| rdy_in | input | 1 | Asynchronous ready from memory or I/O |
| cpu_clk | output | 1 | Processor clock, one-third duty cycle |
| per_clk | output | 1 | Peripheral clock, half the processor clock rate |
| osc_out | output | 1 | Buffered copy of the oscillator input |
| cpu_rst | output | 1 | Synchronized, width-stretched processor reset |
| cpu_rdy | output | 1 | Ready, synchronized to processor clock rises |

## Verification
A selected source edge reaches `cpu_clk` and `per_clk` two reference edges after it is first sampled. The bench holds each source period for four reference cycles and samples only at the last falling reference edge of that period, so every divider result has settled. Reset and ready effects are due at particular processor clock edges, not at a fixed cycle count. The bench therefore numbers the source edges since reset and checks `cpu_rst` and `cpu_rdy` on both sides of the edge where each change is due. The buffered oscillator copy is due one reference edge later and is sampled at the next falling edge.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    // divide ratio of the processor clock; fixed by the duty-cycle rule
    localparam int CLKGEN_DIV = 3;
    localparam int CLKGEN_PW  = $clog2(CLKGEN_DIV);

    typedef logic [CLKGEN_PW-1:0] clkgen_ph_t;

    typedef struct packed {
        clkgen_ph_t ph;
        logic       cpu;
        logic       per;
    } clkgen_div_t;

    typedef struct packed {
        logic meta;
        logic rdy;
    } clkgen_rdy_t;

endpackage

// File: rtl/clkgen_edge.sv
module clkgen_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic osc_in,
    input  logic ext_in,
    output logic osc_out,
    output logic rise
);
    typedef struct packed {
        logic [SYNC-1:0] sh;
        logic            prev;
        logic            osc;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[SYNC-2:0], (sel ? ext_in : osc_in)};
        st_d.prev = st_q.sh[SYNC-1];
        st_d.osc  = osc_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise    = st_q.sh[SYNC-1] & ~st_q.prev;
    assign osc_out = st_q.osc;
endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic cpu_clk,
    output logic per_clk,
    output logic cpu_rise,
    output logic cpu_fall
);
    clkgen_div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (rise) begin
            div_d.cpu = (div_q.ph == '0);
            if (div_q.ph == '0) div_d.per = ~div_q.per;
            div_d.ph = (div_q.ph == clkgen_ph_t'(CLKGEN_DIV-1)) ? '0 : div_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // strobes mark the reference cycle in which the outputs move
    assign cpu_rise = rise && (div_q.ph == '0);
    assign cpu_fall = rise && (div_q.ph == clkgen_ph_t'(1));
    assign cpu_clk  = div_q.cpu;
    assign per_clk  = div_q.per;
endmodule

// File: rtl/clkgen_rst.sv
module clkgen_rst #(
    parameter int SYNC    = 2,
    parameter int RST_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic fall,
    output logic cpu_rst
);
    localparam int HW = $clog2(RST_MIN);

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic            pend;
        logic [HW-1:0]   hold;
        logic            out;
    } rst_st_t;

    rst_st_t rs_d, rs_q;
    logic    want;

    always_comb begin
        rs_d      = rs_q;
        want      = rs_q.pend | rs_q.sync[SYNC-1];
        rs_d.sync = {rs_q.sync[SYNC-2:0], req};
        rs_d.pend = want;
        if (fall) begin
            rs_d.out  = want | (rs_q.hold != '0);
            rs_d.pend = 1'b0;
            if (want)                rs_d.hold = HW'(RST_MIN-1);
            else if (rs_q.hold != '0) rs_d.hold = rs_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q      <= '0;
            rs_q.out  <= 1'b1;
            rs_q.hold <= HW'(RST_MIN-1);
        end else begin
            rs_q <= rs_d;
        end
    end

    assign cpu_rst = rs_q.out;
endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
    import clkgen_pkg::*;
#(
    parameter int SYNC    = 2,
    parameter int RST_MIN = 4
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic osc_in,
    input  logic ext_in,
    input  logic rst_req,
    input  logic rdy_in,
    output logic cpu_clk,
    output logic per_clk,
    output logic osc_out,
    output logic cpu_rst,
    output logic cpu_rdy
);
    logic src_rise, c_rise, c_fall;
    clkgen_rdy_t rdy_d, rdy_q;

    clkgen_edge #(.SYNC(SYNC)) u_edge (
        .clk(ref_clk), .rst_n(rst_n), .sel(src_sel), .osc_in(osc_in),
        .ext_in(ext_in), .osc_out(osc_out), .rise(src_rise)
    );

    clkgen_div u_div (
        .clk(ref_clk), .rst_n(rst_n), .rise(src_rise), .cpu_clk(cpu_clk),
        .per_clk(per_clk), .cpu_rise(c_rise), .cpu_fall(c_fall)
    );

    clkgen_rst #(.SYNC(SYNC), .RST_MIN(RST_MIN)) u_rst (
        .clk(ref_clk), .rst_n(rst_n), .req(rst_req), .fall(c_fall), .cpu_rst(cpu_rst)
    );

    always_comb begin
        rdy_d      = rdy_q;
        rdy_d.meta = rdy_in;
        if (c_rise) rdy_d.rdy = rdy_q.meta;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= '0;
        else        rdy_q <= rdy_d;
    end

    assign cpu_rdy = rdy_q.rdy;
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
    parameter int RST_MIN = 4
) (
    input logic ref_clk,
    input logic rst_n,
    input logic osc_in,
    input logic osc_out,
    input logic cpu_clk,
    input logic per_clk,
    input logic cpu_rst,
    input logic cpu_rdy
);
    localparam int CW = $clog2(RST_MIN+1) + 1;

    logic          up_q, clk_p, rst_p;
    logic [CW-1:0] rises_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q    <= 1'b0;
            clk_p   <= 1'b0;
            rst_p   <= 1'b1;
            rises_q <= '0;
        end else begin
            up_q  <= 1'b1;
            clk_p <= cpu_clk;
            rst_p <= cpu_rst;
            if (cpu_rst && !rst_p)
                rises_q <= '0;
            else if (cpu_rst && cpu_clk && !clk_p && (rises_q != '1))
                rises_q <= rises_q + 1'b1;
        end
    end

    // R4: peripheral clock moves exactly with processor clock rises
    assert_per_on_rise_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(cpu_clk) |-> !$stable(per_clk));
    assert_per_only_rise_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$stable(per_clk) |-> $rose(cpu_clk));
    // R5: buffered oscillator copy
    assert_osc_copy_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        up_q |-> (osc_out == $past(osc_in)));
    // R6: reset output moves only on a processor clock fall
    assert_rst_on_fall_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$stable(cpu_rst) |-> ($past(cpu_clk) && !cpu_clk));
    // R7 and R8: minimum reset width in processor clock periods
    assert_rst_width_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(cpu_rst) |-> (rises_q >= CW'(RST_MIN)));
    // R9: ready moves only on a processor clock rise
    assert_rdy_on_rise_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$stable(cpu_rdy) |-> $rose(cpu_clk));
endmodule

bind cpu_clkgen clkgen_chk #(.RST_MIN(RST_MIN)) u_chk (
    .ref_clk(ref_clk), .rst_n(rst_n), .osc_in(osc_in), .osc_out(osc_out),
    .cpu_clk(cpu_clk), .per_clk(per_clk), .cpu_rst(cpu_rst), .cpu_rdy(cpu_rdy)
);

// File: tb/sim_cpu_clkgen.sv
module sim_cpu_clkgen;
    logic ref_clk = 1'b0;
    logic rst_n, src_sel, osc_in, ext_in, rst_req, rdy_in;
    logic cpu_clk, per_clk, osc_out, cpu_rst, cpu_rdy;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2 ref_clk = ~ref_clk;   // 250 MHz

    cpu_clkgen u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .src_sel(src_sel), .osc_in(osc_in),
        .ext_in(ext_in), .rst_req(rst_req), .rdy_in(rdy_in), .cpu_clk(cpu_clk),
        .per_clk(per_clk), .osc_out(osc_out), .cpu_rst(cpu_rst), .cpu_rdy(cpu_rdy)
    );

    // {src_sel, pulse osc_in, pulse ext_in, expected cpu_clk, expected per_clk}
    localparam logic [4:0] VEC [12] = '{
        5'b0_10_11, 5'b0_10_01, 5'b0_01_01, 5'b0_10_01,
        5'b0_10_10, 5'b1_10_10, 5'b1_01_00, 5'b1_01_00,
        5'b1_01_11, 5'b1_01_01, 5'b1_01_01, 5'b1_01_10
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // one source period: two reference cycles high, two low
    task automatic period(input logic po, input logic pe);
        osc_in = po;
        ext_in = pe;
        repeat (2) @(negedge ref_clk);
        osc_in = 1'b0;
        ext_in = 1'b0;
        repeat (2) @(negedge ref_clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) period(1'b1, 1'b0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge ref_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; src_sel = 1'b0; osc_in = 1'b0; ext_in = 1'b0;
        rst_req = 1'b0; rdy_in = 1'b0;
        repeat (4) @(negedge ref_clk);
        chk("R1 cpu_clk", cpu_clk, 1'b0);
        chk("R1 per_clk", per_clk, 1'b0);
        chk("R1 cpu_rdy", cpu_rdy, 1'b0);
        chk("R1 osc_out", osc_out, 1'b0);
        chk("R1 cpu_rst", cpu_rst, 1'b1);
        rst_n = 1'b1;
        @(negedge ref_clk);

        // R2 R3 R4: divider walk across both sources
        for (int i = 0; i < 12; i++) begin
            src_sel = VEC[i][4];
            period(VEC[i][3], VEC[i][2]);
            chk($sformatf("R3 R2 step %0d cpu_clk", i), cpu_clk, VEC[i][1]);
            chk($sformatf("R4 R2 step %0d per_clk", i), per_clk, VEC[i][0]);
        end

        // fresh power-on for the reset and ready sequences
        rst_n = 1'b0;
        src_sel = 1'b0;
        repeat (3) @(negedge ref_clk);
        rst_n = 1'b1;
        @(negedge ref_clk);
        run(10);
        chk("R8 held through edge 10", cpu_rst, 1'b1);
        run(1);
        chk("R8 released at edge 11", cpu_rst, 1'b0);

        rst_req = 1'b1;
        repeat (3) @(negedge ref_clk);
        rst_req = 1'b0;
        repeat (4) @(negedge ref_clk);
        run(2);
        chk("R7 R6 not before fall (edge 13)", cpu_rst, 1'b0);
        run(1);
        chk("R7 set at fall (edge 14)", cpu_rst, 1'b1);
        run(11);
        chk("R7 still high at edge 25", cpu_rst, 1'b1);
        run(1);
        chk("R7 released at edge 26", cpu_rst, 1'b0);

        rst_req = 1'b1;
        run(6);
        chk("R7 held request keeps reset", cpu_rst, 1'b1);
        rst_req = 1'b0;

        rdy_in = 1'b1;
        run(1);
        chk("R9 no load off a rise (edge 33)", cpu_rdy, 1'b0);
        run(1);
        chk("R9 load at rise (edge 34)", cpu_rdy, 1'b1);
        rdy_in = 1'b0;
        run(2);
        chk("R9 hold until rise (edge 36)", cpu_rdy, 1'b1);
        run(1);
        chk("R9 load at rise (edge 37)", cpu_rdy, 1'b0);

        src_sel = 1'b1;
        osc_in = 1'b1;
        @(negedge ref_clk);
        chk("R5 osc_out high", osc_out, 1'b1);
        osc_in = 1'b0;
        @(negedge ref_clk);
        chk("R5 osc_out low", osc_out, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule